// File: doc/BRIEF.md
# Fixed-Ratio Interpolating Rate Converter (435:256)

This block takes a continuous stream of signed 12-bit samples clocked at the fast input rate and delivers the same waveform at a slower rate. The two rates stand in the ratio 435 to 256. For each output instant the block forms a weighted sum over a window of 2A+1 consecutive input samples, with A = 8, giving 17 taps. The output instant lies a fraction of an input period after one of the input samples. That fraction takes one of 256 values and repeats, so every tap has a weight table of 256 entries indexed by the output phase.

An input-domain scheduler decides, input cycle by input cycle, whether an output is formed. It walks a 256-bit map computed at elaboration, with one bit per output phase. A set bit means the next input cycle is idle. The same scheduler steps the phase that addresses the weight tables. Only scheduled results are written into a small dual-clock FIFO. The slower clock domain reads that FIFO. The FIFO therefore sees 256 writes in every 435 input cycles and never overflows while the reader keeps up.

The weight tables are computed by a package function. The default is a linear-interpolation kernel on the two taps that straddle the output instant. Sums are rounded and clamped back to 12 bits.

Top module: `frac_resampler`

## Requirements
- R1: While either reset is held, and in the first input cycle after the input side leaves reset, `out_empty` is 1.
- R2: In every run of 435 input cycles counted from reset, exactly 256 results are produced. The schedule repeats with that period, so output k+256 uses the samples 435 positions later than output k.
- R3: Output k (counting from 0 after reset) is formed in input cycle floor(435·k/256) after reset. Two idle cycles never occur in a row. The phase advances by one (modulo 256) on each result and holds on idle cycles.
- R4: Take mk = floor(435·k/256) and µ = (435·k) mod 256. Output k equals the rounded value of (Wn·x[mk−9] + Wf·x[mk−8]) / 1024, where x[i] is the i-th input sample after reset, Wf = 4µ and Wn = 1024 − 4µ. The other 15 taps carry weight 0.
- R5: Rounding is floor(s/1024 + 1/2), taken on the full-precision sum s. The result is clamped to the range −2048 to 2047.
- R6: A constant input appears unchanged at the output once the window has filled. This holds at both extremes of the 12-bit range.
- R7: The FIFO never reports full while the reader drains it at least as fast as results arrive. Results leave in the order they were formed, with none lost.
- R8: The sample window is cleared by reset, so samples with a negative index x[i<0] count as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Fast input-rate clock |
| in_rst_n | input | 1 | Active-low asynchronous reset, input side |
| in_sample | input | 12 | Signed input sample, one per in_clk |
| out_clk | input | 1 | Slow output-rate clock |
| out_rst_n | input | 1 | Active-low asynchronous reset, output side |
| out_rd | input | 1 | Pops the head word at the next out_clk edge |
| out_sample | output | 12 | Signed head word of the FIFO, valid when not empty |
| out_empty | output | 1 | FIFO holds no result |

## Verification
Output k is formed combinationally in input cycle floor(435·k/256). It is captured at the next input edge and written into the FIFO at the edge after that. It then becomes visible on the read side only after a two-flop pointer synchronizer in the output domain. Because that crossing latency is not a fixed cycle count, the bench does not compare data at fixed edges. It drains the FIFO on every falling out_clk edge and compares each word by its sequence index against a model written from R4 and R5. Empty checks are placed at points where no write can yet have reached the read side: during reset, and one input edge after release, since the first write needs two input edges.

// File: rtl/resamp_pkg.sv
package resamp_pkg;

  // Input slot (cycle after reset) in which output k is formed.
  function automatic int slot_of(input int k, input int in_per, input int out_per);
    return (k * in_per) / out_per;
  endfunction

  // Fractional position of output k past its preceding input, in 1/out_per units.
  function automatic int frac_of(input int k, input int in_per, input int out_per);
    return (k * in_per) % out_per;
  endfunction

  // Weight of one tap at one phase; linear kernel across the straddling pair.
  function automatic int tap_weight(input int tap, input int phase, input int half,
                                    input int in_per, input int out_per, input int frac_bits);
    int mu;
    int step;
    int unity;
    unity = 1 << frac_bits;
    step  = unity / out_per;
    mu    = frac_of(phase, in_per, out_per);
    if (tap == half)     return unity - mu * step;
    if (tap == half - 1) return mu * step;
    return 0;
  endfunction

endpackage

// File: rtl/resamp_sched.sv
module resamp_sched #(
  parameter int IN_PER  = 435,
  parameter int OUT_PER = 256,
  parameter int PW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          emit,
  output logic [PW-1:0] phase
);

  // Bit k set: output k+1 lies two input slots after output k.
  function automatic logic [OUT_PER-1:0] build_map();
    logic [OUT_PER-1:0] m;
    for (int k = 0; k < OUT_PER; k++)
      m[k] = (resamp_pkg::slot_of(k + 1, IN_PER, OUT_PER)
              - resamp_pkg::slot_of(k, IN_PER, OUT_PER)) > 1;
    return m;
  endfunction

  localparam logic [OUT_PER-1:0] SKIP_MAP = build_map();
  localparam logic [PW-1:0]      LAST_PH  = PW'(OUT_PER - 1);

  logic          idle_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      phase_q <= '0;
    end else if (!idle_q) begin
      phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
      idle_q  <= SKIP_MAP[phase_q];
    end else begin
      idle_q  <= 1'b0;
    end
  end

  assign emit  = !idle_q;
  assign phase = phase_q;

endmodule

// File: rtl/resamp_fir.sv
module resamp_fir #(
  parameter int DW      = 12,
  parameter int CW      = 12,
  parameter int HALF    = 8,
  parameter int IN_PER  = 435,
  parameter int OUT_PER = 256,
  parameter int FRAC    = 10,
  parameter int PW      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] din,
  input  logic                 emit,
  input  logic [PW-1:0]        phase,
  output logic signed [DW-1:0] dout,
  output logic                 dout_vld
);

  localparam int TAPS = 2 * HALF + 1;
  localparam int PRW  = DW + CW;
  localparam int ACCW = PRW + $clog2(TAPS) + 1;
  localparam logic signed [ACCW-1:0] RND_HALF = ACCW'(1 << (FRAC - 1));
  localparam logic signed [ACCW-1:0] SAT_HI   = ACCW'((1 << (DW - 1)) - 1);
  localparam logic signed [ACCW-1:0] SAT_LO   = ACCW'(-(1 << (DW - 1)));

  function automatic logic signed [DW-1:0] round_sat(input logic signed [ACCW-1:0] s);
    logic signed [ACCW-1:0] r;
    r = (s + RND_HALF) >>> FRAC;
    if (r > SAT_HI) return SAT_HI[DW-1:0];
    if (r < SAT_LO) return SAT_LO[DW-1:0];
    return r[DW-1:0];
  endfunction

  logic signed [DW-1:0]   win  [TAPS];
  logic signed [CW-1:0]   coef [TAPS];
  logic signed [PRW-1:0]  prod [TAPS];
  logic signed [ACCW-1:0] acc;

  // Window: position 0 holds the newest sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < TAPS; j++) win[j] <= '0;
    end else begin
      win[0] <= din;
      for (int j = 1; j < TAPS; j++) win[j] <= win[j-1];
    end
  end

  // One phase-indexed weight table per tap.
  for (genvar j = 0; j < TAPS; j++) begin : g_tap
    assign coef[j] = CW'(resamp_pkg::tap_weight(j, int'(phase), HALF, IN_PER, OUT_PER, FRAC));
    assign prod[j] = coef[j] * win[j];
  end

  always_comb begin
    acc = '0;
    for (int j = 0; j < TAPS; j++) acc = acc + ACCW'(prod[j]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= emit;
      if (emit) dout <= round_sat(acc);
    end
  end

endmodule

// File: rtl/resamp_afifo.sv
module resamp_afifo #(
  parameter int DW = 12,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wen,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ren,
  output logic [DW-1:0] rdata,
  output logic          rempty
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, wbin_nx, wgray_nx;
  logic [AW:0] rbin, rgray, rbin_nx, rgray_nx;
  logic [AW:0] rg_w1, rg_w2, wg_r1, wg_r2;
  logic        wfull_q, rempty_q;

  assign wbin_nx  = wbin + (AW+1)'(wen && !wfull_q);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign rbin_nx  = rbin + (AW+1)'(ren && !rempty_q);
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;

  always_ff @(posedge wclk) begin
    if (wen && !wfull_q) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin <= '0; wgray <= '0; rg_w1 <= '0; rg_w2 <= '0; wfull_q <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      rg_w1   <= rgray;
      rg_w2   <= rg_w1;
      wfull_q <= (wgray_nx == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin <= '0; rgray <= '0; wg_r1 <= '0; wg_r2 <= '0; rempty_q <= 1'b1;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      wg_r1    <= wgray;
      wg_r2    <= wg_r1;
      rempty_q <= (rgray_nx == wg_r2);
    end
  end

  assign rdata  = mem[rbin[AW-1:0]];
  assign wfull  = wfull_q;
  assign rempty = rempty_q;

endmodule

// File: rtl/frac_resampler.sv
module frac_resampler #(
  parameter int DW      = 12,
  parameter int CW      = 12,
  parameter int HALF    = 8,
  parameter int IN_PER  = 435,
  parameter int OUT_PER = 256,
  parameter int FRAC    = 10,
  parameter int FIFO_AW = 4
) (
  input  logic                 in_clk,
  input  logic                 in_rst_n,
  input  logic signed [DW-1:0] in_sample,
  input  logic                 out_clk,
  input  logic                 out_rst_n,
  input  logic                 out_rd,
  output logic signed [DW-1:0] out_sample,
  output logic                 out_empty
);

  localparam int PW = $clog2(OUT_PER);

  // Named internal events, observed by the bound checker.
  logic                 sched_emit;
  logic [PW-1:0]        sched_phase;
  logic signed [DW-1:0] fir_word;
  logic                 fir_vld;
  logic                 fifo_full;
  logic [DW-1:0]        fifo_rdata;

  resamp_sched #(.IN_PER(IN_PER), .OUT_PER(OUT_PER), .PW(PW)) u_sched (
    .clk   (in_clk),
    .rst_n (in_rst_n),
    .emit  (sched_emit),
    .phase (sched_phase)
  );

  resamp_fir #(
    .DW(DW), .CW(CW), .HALF(HALF), .IN_PER(IN_PER),
    .OUT_PER(OUT_PER), .FRAC(FRAC), .PW(PW)
  ) u_fir (
    .clk      (in_clk),
    .rst_n    (in_rst_n),
    .din      (in_sample),
    .emit     (sched_emit),
    .phase    (sched_phase),
    .dout     (fir_word),
    .dout_vld (fir_vld)
  );

  resamp_afifo #(.DW(DW), .AW(FIFO_AW)) u_fifo (
    .wclk   (in_clk),
    .wrst_n (in_rst_n),
    .wen    (fir_vld),
    .wdata  (fir_word),
    .wfull  (fifo_full),
    .rclk   (out_clk),
    .rrst_n (out_rst_n),
    .ren    (out_rd),
    .rdata  (fifo_rdata),
    .rempty (out_empty)
  );

  assign out_sample = fifo_rdata;

endmodule

// File: rtl/frac_resampler_chk.sv
module frac_resampler_chk #(
  parameter int IN_PER  = 435,
  parameter int OUT_PER = 256,
  parameter int PW      = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          emit,
  input logic [PW-1:0] phase,
  input logic          full
);

  localparam int CYW = $clog2(IN_PER);

  logic [CYW-1:0] cyc_q;
  logic [PW:0]    cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      cnt_q <= '0;
    end else if (int'(cyc_q) == IN_PER - 1) begin
      cyc_q <= '0;
      cnt_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(emit);
    end
  end

  // R2
  period_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cyc_q) == IN_PER - 1) |-> (int'(cnt_q) + int'(emit) == OUT_PER));

  // R3
  single_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> emit);

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (int'(phase) == (int'($past(phase)) + 1) % OUT_PER));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !emit |=> $stable(phase));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full);

endmodule

bind frac_resampler frac_resampler_chk #(
  .IN_PER(IN_PER), .OUT_PER(OUT_PER), .PW(PW)
) u_chk (
  .clk   (in_clk),
  .rst_n (in_rst_n),
  .emit  (sched_emit),
  .phase (sched_phase),
  .full  (fifo_full)
);

// File: tb/frac_resampler_test.sv
module frac_resampler_test;

  localparam int A     = 8;
  localparam int INP   = 435;
  localparam int OUTP  = 256;
  localparam int NRAMP = 600;
  localparam int NDC   = 5;
  localparam int DC_IN  [NDC] = '{100, -2048, 2047, 0, -1};
  localparam int DC_EXP [NDC] = '{100, -2048, 2047, 0, -1};

  logic in_clk = 1'b0, out_clk = 1'b0;
  logic in_rst_n, out_rst_n, out_rd, out_empty;
  logic signed [11:0] in_sample, out_sample;

  int  checks = 0, fails = 0;
  bit  hold_rst = 1'b1;
  bit  rx_en = 1'b0;
  int  j_in = 0, mode = 0, dc_val = 0, rx_n = 0;
  int  rxbuf [1024];

  frac_resampler uut (
    .in_clk(in_clk), .in_rst_n(in_rst_n), .in_sample(in_sample),
    .out_clk(out_clk), .out_rst_n(out_rst_n), .out_rd(out_rd),
    .out_sample(out_sample), .out_empty(out_empty)
  );

  initial forever #5 in_clk = ~in_clk;
  initial forever #8 out_clk = ~out_clk;

  function automatic int ramp_val(input int i);
    if (i < 0) return 0;               // R8: nothing before reset
    return ((i * 37) % 4000) - 2000;
  endfunction

  function automatic int stim(input int i);
    return (mode == 1) ? dc_val : ramp_val(i);
  endfunction

  // Expected output k per R4 and R5.
  function automatic int model(input int k);
    int mk, mu, wf, wn, s, r;
    mk = (k * INP) / OUTP;
    mu = (k * INP) % OUTP;
    wf = 4 * mu;
    wn = 1024 - wf;
    s  = wn * ramp_val(mk - A - 1) + wf * ramp_val(mk - A);
    r  = (s + 512) >>> 10;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return r;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Input driver: one sample per input cycle, changed on the falling edge.
  initial begin
    in_rst_n = 1'b0;
    in_sample = '0;
    forever begin
      @(negedge in_clk);
      if (hold_rst) begin
        in_rst_n = 1'b0; j_in = 0; in_sample = '0;
      end else begin
        in_rst_n = 1'b1; in_sample = 12'(stim(j_in)); j_in++;
      end
    end
  end

  // Reader: drains one word per output cycle whenever one is present.
  initial begin
    out_rd = 1'b0;
    forever begin
      @(negedge out_clk);
      if (rx_en && out_rst_n && !out_empty) begin
        if (rx_n < 1024) rxbuf[rx_n] = int'(out_sample);
        rx_n++;
        out_rd = 1'b1;
      end else begin
        out_rd = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge in_clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    string tag;
    int base;
    out_rst_n = 1'b0;
    repeat (4) @(posedge in_clk);
    #1 check("R1 empty in reset", int'(out_empty), 1);
    @(posedge out_clk); #1 out_rst_n = 1'b1; rx_en = 1'b1;
    repeat (3) @(posedge in_clk);
    #1 check("R1 empty with input side held", int'(out_empty), 1);
    hold_rst = 1'b0;
    @(negedge in_clk);
    @(posedge in_clk);
    #1 check("R1 empty after first input edge", int'(out_empty), 1);

    // Interpolation and schedule over more than two periods.
    while (rx_n < NRAMP) @(posedge in_clk);
    for (int k = 0; k < NRAMP; k++) begin
      if ((k * INP) / OUTP < A + 1) tag = $sformatf("R8 R4 output %0d", k);
      else if (k < OUTP)            tag = $sformatf("R3 R4 R5 output %0d", k);
      else                          tag = $sformatf("R2 R4 R5 R7 output %0d", k);
      check(tag, rxbuf[k], model(k));
    end

    // Constant levels, one table entry at a time.
    @(posedge in_clk); #1 mode = 1;
    for (int v = 0; v < NDC; v++) begin
      dc_val = DC_IN[v];
      base = rx_n;
      while (rx_n < base + 56) @(posedge in_clk);
      for (int i = 40; i < 48; i++)
        check($sformatf("R6 level %0d word %0d", DC_IN[v], i), rxbuf[base + i], DC_EXP[v]);
      @(posedge in_clk); #1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule